// File: doc/BRIEF.md
# Burst Write Beat Driver with Byte-Lane Odd Parity

This block sits between a core's store path and a 64-bit data bus that is split into a high word and a low word of 32 bits each, with one parity line per byte. The core hands over a write of either one beat or a four-beat burst, together with a byte-lane select mask (used only for single beats), and the block drives those beats onto the bus in step with the bus handshake. The handshake signals are data-bus-busy, transfer acknowledge, transfer error and a retry abort. A drive-enable output tells the pad ring when the data and parity lines are driven; when it is low, the lines are at high impedance.

Each byte lane carries odd parity generated from the byte actually driven. A configuration input selects whether parity is generated. The same per-lane parity logic checks read beats, which are captured on transfer acknowledge during a read tenure and reported one cycle later with a per-lane error flag.

Top module: `bdb_driver`

## Requirements
- R1: While driving with `par_en` high, every lane holds an odd number of ones across its 8 data bits and its parity bit.
- R2: Lane k of `wr_par` covers bus byte k, counted from the most significant end. Lanes 0..3 are `wr_hi[31:24]`, `[23:16]`, `[15:8]`, `[7:0]` and lanes 4..7 are the same slices of `wr_lo`. Beat data is packed as `{hi,lo}` = 64 bits, with beat n at `req_data[64n +: 64]`.
- R3: With `par_en` low, `wr_par` is driven as all ones during a data tenure and `rd_perr` stays zero.
- R4: Once a request is held, the first beat and its parity are driven (`wr_oe`=1) in the same cycle `bus_busy` is first seen high, and the beat index is 0.
- R5: A burst (`req_burst`=1) has four beats. The driven beat moves to the next one in the cycle after each acknowledge given while driving. A single transfer has one beat.
- R6: `wr_oe` falls in the cycle after the acknowledge of the final beat, and all write outputs read zero while `wr_oe` is low.
- R7: `xfer_err` or `retry_abort` while driving ends the tenure, so `wr_oe` is low in the next cycle and the request is dropped.
- R8: On a single beat, a lane whose `req_mask` bit (bit k is lane k) is 0 is driven as zero and selected bytes are never mirrored. The mask is ignored for bursts.
- R9: When `xfer_ack` is high with `rd_tenure` high and no write being driven, `{rd_hi,rd_lo}` is captured and presented on `rd_word` with `rd_valid` high for exactly the next cycle.
- R10: With `par_en` high, `rd_perr[k]` is raised together with `rd_valid` for a captured lane whose 8 bits plus parity bit hold an even number of ones.
- R11: `req_ready` is high only with no request held, and `req_valid` while it is low has no effect on the beats driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core offers a write request |
| req_ready | output | 1 | No request held; offer is taken |
| req_burst | input | 1 | 1 = four-beat burst, 0 = single beat |
| req_data | input | 256 | Beat n at bits [64n +: 64], packed {hi,lo} |
| req_mask | input | 8 | Lane select for single beats, bit k = lane k |
| par_en | input | 1 | Parity generation and checking enable |
| bus_busy | input | 1 | Data-bus-busy, start of data tenure |
| xfer_ack | input | 1 | Transfer acknowledge |
| xfer_err | input | 1 | Transfer error |
| retry_abort | input | 1 | Retry abort of the tenure |
| wr_hi | output | 32 | High data word driven |
| wr_lo | output | 32 | Low data word driven |
| wr_par | output | 8 | Per-lane parity driven |
| wr_oe | output | 1 | Drive enable; 0 = high impedance |
| rd_tenure | input | 1 | A read data tenure is in progress |
| rd_hi | input | 32 | High data word from the bus |
| rd_lo | input | 32 | Low data word from the bus |
| rd_par | input | 8 | Parity lines from the bus |
| rd_valid | output | 1 | Captured read beat present |
| rd_word | output | 64 | Captured read beat {hi,lo} |
| rd_perr | output | 8 | Per-lane read parity error |

## Verification
The hardest case to reach is an acknowledge or error that lands on the very cycle `bus_busy` first rises. In that cycle the tenure's drive enable is still coming from the combinational path and the state register has not yet moved. The stimulus holds a request, then raises `bus_busy` together with `xfer_ack`, and separately together with `xfer_err`. This exercises first-cycle completion and first-cycle abort. It also offers new requests while one is already held and mixes acknowledge gaps into bursts, and a behavioural model checks every output on every clock.

// File: rtl/bdb_pkg.sv
package bdb_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_WAIT  = 2'd1,
      SEQ_DRIVE = 2'd2
   } seq_state_t;
endpackage

// File: rtl/bdb_lane_par.sv
module bdb_lane_par #(
   parameter int LANE_W = 8
) (
   input  logic              par_en,
   input  logic [LANE_W-1:0] wr_byte,
   output logic              par_o,
   input  logic [LANE_W-1:0] rd_byte,
   input  logic              rd_par,
   output logic              rd_bad
);
   generate
      if (LANE_W < 1) begin : g_bad_w
         $error("bdb_lane_par: LANE_W must be positive");
      end
   endgenerate

   // odd parity: parity bit makes the total count of ones odd
   always_comb begin
      par_o  = par_en ? ~(^wr_byte) : 1'b1;
      rd_bad = par_en & ~(^{rd_byte, rd_par});
   end
endmodule

// File: rtl/bdb_beat_seq.sv
module bdb_beat_seq
   import bdb_pkg::*;
#(
   parameter int BEATS = 4,
   localparam int CNT_W = $clog2(BEATS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_burst,
   output logic             req_ready,
   output logic             load,
   output logic             burst_q,
   input  logic             bus_busy,
   input  logic             xfer_ack,
   input  logic             xfer_err,
   input  logic             retry_abort,
   output logic             drive,
   output logic [CNT_W-1:0] beat
);
   generate
      if (BEATS < 2) begin : g_bad_beats
         $error("bdb_beat_seq: BEATS must be at least 2");
      end
   endgenerate

   seq_state_t st_q, st_d;
   logic [CNT_W-1:0] beat_d;
   logic last_beat, stop;

   assign req_ready = (st_q == SEQ_IDLE);
   assign load      = req_ready & req_valid;
   assign drive     = (st_q == SEQ_DRIVE) | ((st_q == SEQ_WAIT) & bus_busy);
   assign last_beat = burst_q ? (beat == CNT_W'(BEATS-1)) : (beat == '0);
   assign stop      = xfer_err | retry_abort;

   always_comb begin
      st_d   = st_q;
      beat_d = beat;
      if (load) begin
         st_d   = SEQ_WAIT;
         beat_d = '0;
      end else if (drive) begin
         if (stop) begin
            st_d = SEQ_IDLE;
         end else if (xfer_ack) begin
            if (last_beat) begin
               st_d = SEQ_IDLE;
            end else begin
               st_d   = SEQ_DRIVE;
               beat_d = beat + 1'b1;
            end
         end else begin
            st_d = SEQ_DRIVE;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= SEQ_IDLE;
         beat    <= '0;
         burst_q <= 1'b0;
      end else begin
         st_q <= st_d;
         beat <= beat_d;
         if (load) burst_q <= req_burst;
      end
   end

   p_first_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SEQ_WAIT && bus_busy) |-> (drive && beat == '0));

   p_beat_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (drive && xfer_ack && !stop && !last_beat) |=>
      (drive && beat == CNT_W'($past(beat) + 1'b1)));

   p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (drive && xfer_ack && last_beat) |=> !drive);

   p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (drive && stop) |=> (!drive && req_ready));

   p_no_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && req_valid) |=> $stable(burst_q));
endmodule

// File: rtl/bdb_driver.sv
module bdb_driver #(
   parameter int WORD_W = 32,
   parameter int LANE_W = 8,
   parameter int BEATS  = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            req_valid,
   output logic                            req_ready,
   input  logic                            req_burst,
   input  logic [BEATS*2*WORD_W-1:0]       req_data,
   input  logic [2*WORD_W/LANE_W-1:0]      req_mask,
   input  logic                            par_en,
   input  logic                            bus_busy,
   input  logic                            xfer_ack,
   input  logic                            xfer_err,
   input  logic                            retry_abort,
   output logic [WORD_W-1:0]               wr_hi,
   output logic [WORD_W-1:0]               wr_lo,
   output logic [2*WORD_W/LANE_W-1:0]      wr_par,
   output logic                            wr_oe,
   input  logic                            rd_tenure,
   input  logic [WORD_W-1:0]               rd_hi,
   input  logic [WORD_W-1:0]               rd_lo,
   input  logic [2*WORD_W/LANE_W-1:0]      rd_par,
   output logic                            rd_valid,
   output logic [2*WORD_W-1:0]             rd_word,
   output logic [2*WORD_W/LANE_W-1:0]      rd_perr
);
   localparam int BUS_W = 2 * WORD_W;
   localparam int LANES = BUS_W / LANE_W;
   localparam int REQ_W = BEATS * BUS_W;
   localparam int CNT_W = $clog2(BEATS);

   generate
      if (BUS_W % LANE_W != 0) begin : g_bad_lane
         $error("bdb_driver: bus width must be a multiple of LANE_W");
      end
      if (WORD_W % LANE_W != 0) begin : g_bad_word
         $error("bdb_driver: each word must hold whole lanes");
      end
   endgenerate

   logic             load, burst_q, drive;
   logic [CNT_W-1:0] beat;
   logic [REQ_W-1:0] data_q;
   logic [LANES-1:0] mask_q;
   logic [BUS_W-1:0] cur_word, drv_word, rd_bus;
   logic [LANES-1:0] par_raw, rd_bad;
   logic             capture;

   bdb_beat_seq #(.BEATS(BEATS)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_burst   (req_burst),
      .req_ready   (req_ready),
      .load        (load),
      .burst_q     (burst_q),
      .bus_busy    (bus_busy),
      .xfer_ack    (xfer_ack),
      .xfer_err    (xfer_err),
      .retry_abort (retry_abort),
      .drive       (drive),
      .beat        (beat)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
         mask_q <= '0;
      end else if (load) begin
         data_q <= req_data;
         mask_q <= req_mask;
      end
   end

   assign cur_word = data_q[beat*BUS_W +: BUS_W];
   assign rd_bus   = {rd_hi, rd_lo};

   // lane k sits at byte k from the most significant end of {hi,lo}
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      localparam int LO = (LANES - 1 - k) * LANE_W;
      logic [LANE_W-1:0] wb;

      assign wb = (!burst_q && !mask_q[k]) ? '0 : cur_word[LO +: LANE_W];
      assign drv_word[LO +: LANE_W] = wb;

      bdb_lane_par #(.LANE_W(LANE_W)) u_par (
         .par_en  (par_en),
         .wr_byte (wb),
         .par_o   (par_raw[k]),
         .rd_byte (rd_bus[LO +: LANE_W]),
         .rd_par  (rd_par[k]),
         .rd_bad  (rd_bad[k])
      );

      p_lane_odd_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_oe && par_en) |-> (^{{wr_hi, wr_lo}[LO +: LANE_W], wr_par[k]}));
   end

   assign wr_oe = drive;
   assign wr_hi = drive ? drv_word[BUS_W-1:WORD_W] : '0;
   assign wr_lo = drive ? drv_word[WORD_W-1:0]     : '0;
   assign wr_par = drive ? par_raw : '0;

   assign capture = xfer_ack & rd_tenure & ~drive;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_word  <= '0;
         rd_perr  <= '0;
      end else begin
         rd_valid <= capture;
         rd_perr  <= capture ? rd_bad : '0;
         if (capture) rd_word <= rd_bus;
      end
   end

   p_par_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_oe && !par_en) |-> (wr_par == '1));

   p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_oe |-> (wr_hi == '0 && wr_lo == '0 && wr_par == '0));

   p_perr_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_perr != '0) |-> rd_valid);

   p_rd_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_ack && rd_tenure && !wr_oe) |=> (rd_valid && rd_word == $past({rd_hi, rd_lo})));
endmodule

// File: tb/test_bdb_driver.sv
module test_bdb_driver;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic         req_valid = 0, req_burst = 0, par_en = 1;
   logic [255:0] req_data = '0;
   logic [7:0]   req_mask = '0;
   logic         bus_busy = 0, xfer_ack = 0, xfer_err = 0, retry_abort = 0;
   logic         rd_tenure = 0;
   logic [31:0]  rd_hi = '0, rd_lo = '0;
   logic [7:0]   rd_par = '0;
   logic         req_ready, wr_oe, rd_valid;
   logic [31:0]  wr_hi, wr_lo;
   logic [7:0]   wr_par, rd_perr;
   logic [63:0]  rd_word;

   bdb_driver i_bdb_driver (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_burst(req_burst), .req_data(req_data), .req_mask(req_mask),
      .par_en(par_en), .bus_busy(bus_busy), .xfer_ack(xfer_ack),
      .xfer_err(xfer_err), .retry_abort(retry_abort), .wr_hi(wr_hi),
      .wr_lo(wr_lo), .wr_par(wr_par), .wr_oe(wr_oe), .rd_tenure(rd_tenure),
      .rd_hi(rd_hi), .rd_lo(rd_lo), .rd_par(rd_par), .rd_valid(rd_valid),
      .rd_word(rd_word), .rd_perr(rd_perr)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // behavioural reference model state
   int          m_st = 0;        // 0 idle, 1 waiting for bus, 2 driving
   int          m_beat = 0;
   bit          m_burst = 0;
   logic [63:0] m_beats [$];
   logic [7:0]  m_mask = '0;
   bit          m_rdv = 0;
   logic [63:0] m_rdw = '0;
   logic [7:0]  m_rderr = '0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] odd_of(input logic [63:0] w, input bit en);
      logic [7:0] p;
      for (int k = 0; k < 8; k++) begin
         logic [7:0] b;
         int ones;
         b = w[63 - 8*k -: 8];
         ones = $countones(b);
         p[k] = en ? ((ones % 2) == 0) : 1'b1;
      end
      return p;
   endfunction

   always begin
      @(negedge clk);
      #3;
      if (!rst_n) begin
         chk("R6 reset oe", {63'd0, wr_oe}, 64'd0);
         chk("R9 reset rd_valid", {63'd0, rd_valid}, 64'd0);
         chk("R11 reset ready", {63'd0, req_ready}, 64'd1);
      end else begin
         bit          e_oe;
         logic [63:0] e_w;
         bit          last;
         e_oe = (m_st == 2) || (m_st == 1 && bus_busy);
         e_w  = '0;
         if (e_oe) begin
            e_w = m_beats[m_beat];
            if (!m_burst)
               for (int k = 0; k < 8; k++)
                  if (!m_mask[k]) e_w[63 - 8*k -: 8] = 8'h00;
         end
         chk("R11 ready", {63'd0, req_ready}, {63'd0, m_st == 0});
         chk("R4/R6/R7 drive enable", {63'd0, wr_oe}, {63'd0, e_oe});
         chk("R5/R8 data", {wr_hi, wr_lo}, e_w);
         chk("R1/R2/R3 parity", {56'd0, wr_par}, {56'd0, e_oe ? odd_of(e_w, par_en) : 8'h00});
         chk("R9 rd_valid", {63'd0, rd_valid}, {63'd0, m_rdv});
         if (m_rdv) chk("R9 rd_word", rd_word, m_rdw);
         chk("R10/R3 rd_perr", {56'd0, rd_perr}, {56'd0, m_rderr});
         // advance the model to the coming edge
         m_rdv = xfer_ack && rd_tenure && !e_oe;
         m_rderr = '0;
         if (m_rdv) begin
            m_rdw = {rd_hi, rd_lo};
            for (int k = 0; k < 8; k++)
               m_rderr[k] = par_en && ($countones({m_rdw[63 - 8*k -: 8], rd_par[k]}) % 2 == 0);
         end
         last = m_burst ? (m_beat == 3) : (m_beat == 0);
         if (m_st == 0) begin
            if (req_valid) begin
               m_st = 1; m_beat = 0; m_burst = req_burst; m_mask = req_mask;
               m_beats = {};
               for (int n = 0; n < 4; n++) m_beats.push_back(req_data[64*n +: 64]);
            end
         end else if (e_oe) begin
            if (xfer_err || retry_abort) m_st = 0;
            else if (xfer_ack) begin
               if (last) m_st = 0;
               else begin m_st = 2; m_beat++; end
            end else m_st = 2;
         end
      end
   end

   task automatic cyc(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic offer(input bit burst, input logic [7:0] mask);
      for (int n = 0; n < 8; n++) req_data[32*n +: 32] = $urandom;
      req_burst = burst; req_mask = mask; req_valid = 1;
      cyc(); req_valid = 0;
   endtask

   initial begin
      cyc(3);
      rst_n = 1;
      cyc(2);
      // R5 burst, acks every cycle, bus granted after a wait
      par_en = 1; offer(1, 8'h00); cyc(2);
      bus_busy = 1; xfer_ack = 1; cyc(4); xfer_ack = 0; bus_busy = 0; cyc(2);
      // R5 burst with gaps; R11 request offered while held
      offer(1, 8'hFF); bus_busy = 1; cyc();
      req_valid = 1; req_data = '1; cyc(); req_valid = 0;
      xfer_ack = 1; cyc(); xfer_ack = 0; cyc(2);
      xfer_ack = 1; cyc(); xfer_ack = 0; cyc();
      xfer_ack = 1; cyc(2); xfer_ack = 0; bus_busy = 0; cyc(2);
      // R8 single beat with lane mask, parity on
      offer(0, 8'b1010_0101); bus_busy = 1; cyc(); xfer_ack = 1; cyc();
      xfer_ack = 0; bus_busy = 0; cyc(2);
      // R3 single beat, parity off
      par_en = 0; offer(0, 8'b0011_1100); bus_busy = 1; cyc(2); xfer_ack = 1; cyc();
      xfer_ack = 0; bus_busy = 0; par_en = 1; cyc(2);
      // R7 burst aborted by transfer error mid-way
      offer(1, 8'h00); bus_busy = 1; xfer_ack = 1; cyc(); xfer_ack = 0; xfer_err = 1; cyc();
      xfer_err = 0; bus_busy = 0; cyc(2);
      // R7 retry abort on a single beat
      offer(0, 8'hFF); bus_busy = 1; cyc(); retry_abort = 1; cyc(); retry_abort = 0;
      bus_busy = 0; cyc(2);
      // R4 ack on the very cycle bus_busy rises
      offer(0, 8'hF0); cyc(); bus_busy = 1; xfer_ack = 1; cyc(); xfer_ack = 0; bus_busy = 0; cyc(2);
      // R7 error on the first cycle of the tenure
      offer(1, 8'h00); bus_busy = 1; xfer_err = 1; cyc(); xfer_err = 0; bus_busy = 0; cyc(2);
      // R9/R10 reads: good, bad parity, gapped, parity off
      rd_tenure = 1;
      for (int i = 0; i < 6; i++) begin
         rd_hi = $urandom; rd_lo = $urandom;
         rd_par = odd_of({rd_hi, rd_lo}, 1);
         if (i % 2 == 1) rd_par = rd_par ^ 8'(1 << i);
         par_en = (i != 5);
         xfer_ack = (i != 3);
         cyc();
      end
      xfer_ack = 0; rd_tenure = 0; par_en = 1; cyc(3);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule